// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised register (eight bits by default) that can hold its contents, shift toward the high bit, shift toward the low bit, or load all bits in parallel. Every change of state happens on the rising clock edge. A synchronous clear takes priority over the mode selects.

Parallel data enters and leaves through one shared bidirectional bus. Three-state drivers place the register contents on that bus. The drivers switch off when either of two active-low enables is high. They also switch off whenever parallel load is selected, so that outside logic can drive the bus. The lowest and highest bits also appear on two dedicated outputs that are always driven. These outputs let several registers be chained for longer serial words.

The register has no asynchronous reset. Its contents are undefined until the first clock edge taken with the clear asserted.

Top module: `bidir_shift_reg`

## Requirements
- R1: When `srst` is 1 at a rising clock edge, every register bit becomes 0, whatever the value of `sel`.
- R2: With `srst` low and `sel` = 2'b11, a rising edge copies the resolved value of `io_data` into the register, with bit i taken from `io_data[i]`.
- R3: With `srst` low and `sel` = 2'b01, a rising edge sets bit 0 to `ser_lo_in` and sets each bit i above 0 to the previous bit i-1.
- R4: With `srst` low and `sel` = 2'b10, a rising edge sets the top bit to `ser_hi_in` and sets each bit i below the top to the previous bit i+1.
- R5: With `srst` low and `sel` = 2'b00, a rising edge leaves the contents unchanged.
- R6: `io_data` is high impedance whenever `oe_a_n` or `oe_b_n` is 1. Otherwise it carries the register contents, unless R7 applies.
- R7: `io_data` is high impedance whenever `sel` = 2'b11, even when both enables are low.
- R8: Clear, load, shifts and hold update the register in the same way whether the bus drivers are enabled or not.
- R9: `tap_lo` always equals register bit 0 and `tap_hi` always equals the top bit, whatever the enables and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous clear, active high, overrides `sel` |
| sel | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| ser_lo_in | input | 1 | Serial bit entering bit 0 on a shift up |
| ser_hi_in | input | 1 | Serial bit entering the top bit on a shift down |
| oe_a_n | input | 1 | Bus driver enable, active low |
| oe_b_n | input | 1 | Bus driver enable, active low |
| io_data | inout | WIDTH | Shared parallel load input and three-state register output |
| tap_lo | output | 1 | Register bit 0, always driven |
| tap_hi | output | 1 | Register top bit, always driven |

## Verification
All 256 parallel load values are read back through the bus in hold mode. Any mixed-up, stuck or dropped bit lane therefore shows up as a wrong value.

Long shift runs in each direction use serial bit streams that are not periodic in the register width. This separates an up shift from a down shift, and a correct neighbour from a wrong or wrapped one.

During the shifts, the enable pair steps through all four combinations. On the released bus a pull-up reads all ones against the register contents, which separates a correct release from a driver that stays on. Running the same operations under both enable settings shows that the register updates whether or not the bus is driven.

Clears are issued under every `sel` code. A load issued with both enables low must capture the pull-up value, which shows that load mode turns the drivers off.

// File: rtl/bidir_shift_pkg.sv
package bidir_shift_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_UP    = 3'd1,
    OP_DOWN  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_CLEAR = 3'd4
  } op_e;

  localparam logic [1:0] SEL_HOLD = 2'b00;
  localparam logic [1:0] SEL_UP   = 2'b01;
  localparam logic [1:0] SEL_DOWN = 2'b10;
  localparam logic [1:0] SEL_LOAD = 2'b11;
endpackage

// File: rtl/bidir_shift_dec.sv
module bidir_shift_dec
  import bidir_shift_pkg::*;
(
  input  logic       srst,
  input  logic [1:0] sel,
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output op_e        op,
  output logic       drive_en
);
  // Clear outranks every select code.
  always_comb begin
    if (srst) op = OP_CLEAR;
    else begin
      unique case (sel)
        SEL_UP:   op = OP_UP;
        SEL_DOWN: op = OP_DOWN;
        SEL_LOAD: op = OP_LOAD;
        default:  op = OP_HOLD;
      endcase
    end
  end

  // Drivers on only when both enables are low and load is not selected.
  always_comb begin
    drive_en = 1'b1;
    if (oe_a_n || oe_b_n) drive_en = 1'b0;
    if (sel == SEL_LOAD)  drive_en = 1'b0;
  end

  always_comb begin
    if (drive_en) begin
      assert_enable_gate_R6: assert (!oe_a_n && !oe_b_n);
      assert_load_release_R7: assert (sel != SEL_LOAD);
    end
  end
endmodule

// File: rtl/bidir_shift_core.sv
module bidir_shift_core
  import bidir_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  op_e              op,
  input  logic             ser_lo,
  input  logic             ser_hi,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] state
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_lo
      assign from_below = ser_lo;
    end else begin : g_lo
      assign from_below = state[i-1];
    end
    if (i == TOP) begin : g_hi
      assign from_above = ser_hi;
    end else begin : g_hi
      assign from_above = state[i+1];
    end

    always_comb begin
      unique case (op)
        OP_CLEAR: nxt[i] = 1'b0;
        OP_LOAD:  nxt[i] = par_in[i];
        OP_UP:    nxt[i] = from_below;
        OP_DOWN:  nxt[i] = from_above;
        default:  nxt[i] = state[i];
      endcase
    end
  end

  // No power-up reset: contents are defined by the first clear.
  always_ff @(posedge clk) begin
    state <= nxt;
  end

  assert_clear_R1: assert property (@(posedge clk)
    (op == OP_CLEAR) |=> (state == '0));
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bidir_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             srst,
  input  logic [1:0]       sel,
  input  logic             ser_lo_in,
  input  logic             ser_hi_in,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  inout  wire  [WIDTH-1:0] io_data,
  output logic             tap_lo,
  output logic             tap_hi
);
  localparam int TOP = WIDTH - 1;

  op_e              op;
  logic             drive_en;
  logic [WIDTH-1:0] state;

  bidir_shift_dec u_dec (
    .srst     (srst),
    .sel      (sel),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .op       (op),
    .drive_en (drive_en)
  );

  bidir_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk    (clk),
    .op     (op),
    .ser_lo (ser_lo_in),
    .ser_hi (ser_hi_in),
    .par_in (io_data),
    .state  (state)
  );

  assign io_data = drive_en ? state : {WIDTH{1'bz}};
  assign tap_lo  = state[0];
  assign tap_hi  = state[TOP];

  // Set by the first clear; lets the checks ignore undefined power-up contents.
  logic primed = 1'b0;
  always_ff @(posedge clk) begin
    if (srst) primed <= 1'b1;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (srst || !primed)
    (sel == SEL_LOAD) |=> (state == $past(io_data)));
  assert_up_entry_R3: assert property (@(posedge clk) disable iff (srst || !primed)
    (sel == SEL_UP) |=> (tap_lo == $past(ser_lo_in)));
  assert_down_entry_R4: assert property (@(posedge clk) disable iff (srst || !primed)
    (sel == SEL_DOWN) |=> (tap_hi == $past(ser_hi_in)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (srst || !primed)
    (sel == SEL_HOLD) |=> $stable(state));
  assert_released_shift_R8: assert property (@(posedge clk) disable iff (srst || !primed)
    ((oe_a_n || oe_b_n) && sel == SEL_UP) |=> (tap_lo == $past(ser_lo_in)));
endmodule

// File: tb/bidir_shift_reg_tb.sv
module bidir_shift_reg_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         srst = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic         ser_lo_in = 1'b0;
  logic         ser_hi_in = 1'b0;
  logic         oe_a_n = 1'b1;
  logic         oe_b_n = 1'b1;
  logic         tb_drive = 1'b0;
  logic [W-1:0] tb_val = '0;
  wire  [W-1:0] bus;
  logic         tap_lo, tap_hi;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] expv = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  for (genvar i = 0; i < W; i++) begin : g_pull
    pullup (bus[i]);
  end
  assign bus = tb_drive ? tb_val : {W{1'bz}};

  bidir_shift_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .srst(srst), .sel(sel), .ser_lo_in(ser_lo_in),
    .ser_hi_in(ser_hi_in), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .io_data(bus), .tap_lo(tap_lo), .tap_hi(tap_hi)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  // Inputs are applied just after a falling edge and results are read at the next falling edge.
  task automatic step(input string tag, input logic r, input logic [1:0] s,
                      input logic d0, input logic d7, input logic [1:0] oe,
                      input logic drv, input logic [W-1:0] dv);
    logic [W-1:0] nxt;
    logic [W-1:0] pins;
    logic         released;
    srst = r; sel = s; ser_lo_in = d0; ser_hi_in = d7;
    oe_a_n = oe[0]; oe_b_n = oe[1]; tb_drive = drv; tb_val = dv;
    released = oe[0] | oe[1] | (s == 2'b11);
    pins = drv ? dv : (released ? {W{1'b1}} : expv);
    if (r)               nxt = '0;
    else if (s == 2'b11) nxt = pins;
    else if (s == 2'b01) nxt = {expv[W-2:0], d0};
    else if (s == 2'b10) nxt = {d7, expv[W-1:1]};
    else                 nxt = expv;
    @(posedge clk);
    @(negedge clk);
    expv = nxt;
    chk({tag, " R9 tap_lo"}, W'(tap_lo), W'(expv[0]));
    chk({tag, " R9 tap_hi"}, W'(tap_hi), W'(expv[W-1]));
    if (!drv) begin
      if (s == 2'b11)    chk({tag, " R7 bus released"}, bus, {W{1'b1}});
      else if (released) chk({tag, " R6 bus released"}, bus, {W{1'b1}});
      else               chk({tag, " R6 bus drives state"}, bus, expv);
    end
  endtask

  task automatic readback(input string tag);
    step(tag, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, '0);
  endtask

  initial begin
    @(negedge clk);
    // R1: clear under every select code, with the bus being driven.
    for (int s = 0; s < 4; s++) begin
      step("R1 clear", 1'b1, 2'(s), 1'b1, 1'b1, 2'b00, 1'b1, 8'hA5);
      readback("R1 clear readback");
    end
    // R2/R5: every load value, then a hold that drives the bus.
    for (int v = 0; v < 256; v++) begin
      step("R2 load", 1'b0, 2'b11, 1'b0, 1'b0, 2'(v % 4), 1'b1, 8'(v));
      readback("R2 R5 load hold");
    end
    // R7: load with both enables low and nothing driving captures the pull-up.
    step("R1 clear", 1'b1, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, '0);
    step("R7 load released", 1'b0, 2'b11, 1'b0, 1'b0, 2'b00, 1'b0, '0);
    readback("R7 captured pull value");
    // R3/R8: upward shifts with all four enable pairs.
    step("R1 clear", 1'b1, 2'b10, 1'b0, 1'b0, 2'b11, 1'b0, '0);
    for (int k = 0; k < 60; k++) begin
      logic b;
      b = logic'(((k * 7) % 11) > 4);
      step("R3 R8 shift up", 1'b0, 2'b01, b, ~b, 2'(k % 4), 1'b0, '0);
    end
    readback("R3 up readback");
    // R4/R8: downward shifts.
    step("R2 load", 1'b0, 2'b11, 1'b0, 1'b0, 2'b01, 1'b1, 8'h3C);
    for (int k = 0; k < 60; k++) begin
      logic b;
      b = logic'(((k * 5) % 13) > 6);
      step("R4 R8 shift down", 1'b0, 2'b10, ~b, b, 2'((k + 1) % 4), 1'b0, '0);
    end
    readback("R4 down readback");
    // R5/R8: hold with the drivers disabled, then read back.
    for (int k = 1; k < 4; k++)
      step("R5 R8 hold released", 1'b0, 2'b00, 1'b1, 1'b1, 2'(k), 1'b0, '0);
    readback("R5 hold readback");
    // R1/R8: a clear while the drivers are disabled.
    step("R2 load", 1'b0, 2'b11, 1'b0, 1'b0, 2'b00, 1'b1, 8'h5A);
    step("R1 R8 clear released", 1'b1, 2'b01, 1'b1, 1'b1, 2'b10, 1'b0, '0);
    readback("R1 clear readback");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule